// File: doc/BRIEF.md
# Multi-Scheme Centralized Bus Arbiter

This block decides which of several requesting modules owns a shared system bus. One arbiter holds three selectable ways of choosing a winner. A position-ordered ripple chain gives the bus to the lowest-numbered requester. A polling counter walks a device number across a shared address bus and grants the module whose number is on the bus while that module is requesting. A bank of dedicated request/grant pairs goes through a fixed lowest-index-wins encoder.

A grant is registered. It stays with its owner for a whole occupancy period. The owner signals the period by holding the bus-busy line high and ends it by dropping that line. Mode changes and request changes during an occupancy have no effect. A new owner is chosen only on a later edge, after the grant has been withdrawn. A build option selects where the polling counter starts on each new round: it restarts at device zero, or it resumes at the device that last owned the bus.

Top module: `bus_arbiter_multi`

## Requirements
- R1: At most one bit of `bus_grant` is high in any cycle.
- R2: While `rst_n` is sampled low, `bus_grant` becomes all zeros and `poll_addr` becomes 0.
- R3: With `scheme_sel` = 0 (chain), no grant held, and `bus_busy` low, if any request is sampled, the next edge sets the grant bit of the lowest-indexed requester.
- R4: With `scheme_sel` = 2 (dedicated pairs), the same conditions as R3 grant the lowest-indexed requester on the next edge.
- R5: With `scheme_sel` = 1 (polling), no grant held, `bus_busy` low and at least one request: if the request at index `poll_addr` is high, that index is granted on the next edge and `poll_addr` holds. Otherwise `poll_addr` advances by one, wrapping from N-1 to 0.
- R6: When an occupancy ends, `poll_addr` returns to 0 if `POLL_RESUME` = 0. If `POLL_RESUME` = 1, it keeps its value, which is the last polled winner.
- R7: While a grant is held and `bus_busy` is sampled high, the grant does not change. This holds whatever `bus_req` and `scheme_sel` do.
- R8: When a grant is held and `bus_busy` is sampled low, the grant clears on that edge. No new grant is issued on that same edge.
- R9: With no grant held, if `bus_busy` is high or `bus_req` is zero, no grant is issued and `poll_addr` does not change.
- R10: `scheme_sel` = 3 is reserved. It never issues a grant and it leaves `poll_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| scheme_sel | input | 2 | 0 chain, 1 polling, 2 dedicated pairs, 3 reserved |
| bus_req | input | N_MASTERS | One request line per module |
| bus_busy | input | 1 | Held high by the owner during its occupancy |
| bus_grant | output | N_MASTERS | One-hot grant, registered |
| poll_addr | output | $clog2(N_MASTERS) | Device number driven by the polling counter |

## Verification
The test bench runs two copies of the block in parallel, one restarting the counter and one resuming it, so every polling round separates the two start rules.

Directed patterns cover several cases:
- A request set with many bits, which shows whether chain and pair modes pick the lowest index.
- A lone request at the top index, which forces the counter to walk the full range and then wrap.
- A busy line raised with no owner, which must block any grant.
- A switch to the reserved mode.
- Request and mode changes during an occupancy, which must leave the grant alone.

Random requests, busy periods and mode choices then mix back-to-back releases with idle gaps. This separates a one-cycle release rule from a release that re-grants on the same edge.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
// Package: shared scheme encoding for the multi-scheme bus arbiter.
package arb_pkg;
    typedef enum logic [1:0] {
        SCH_CHAIN = 2'd0,
        SCH_POLL  = 2'd1,
        SCH_INDEP = 2'd2,
        SCH_RSVD  = 2'd3
    } sched_e;
endpackage

// File: rtl/arb_daisy_chain.sv
`timescale 1ns/1ps
// Module: arb_daisy_chain
// Ripple chain. A pass token enters at index 0 and is absorbed by the first
// requesting position, so the position nearest the arbiter wins.
// Assumes: purely combinational; the caller registers the result.
module arb_daisy_chain #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] win
);
    logic [N:0] pass_tok;

    assign pass_tok[0] = 1'b1;

    // one link per position: take the token if requesting, else pass it on
    for (genvar i = 0; i < N; i++) begin : g_link
        assign win[i]          = pass_tok[i] & req[i];
        assign pass_tok[i + 1] = pass_tok[i] & ~req[i];
    end
endmodule

// File: rtl/arb_fixed_prio.sv
`timescale 1ns/1ps
// Module: arb_fixed_prio
// Priority encoder over dedicated request lines; lowest index wins.
// Assumes: purely combinational; returns zero when no line is raised.
module arb_fixed_prio #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] win
);
    // scan from the top so the lowest raised index is written last
    always_comb begin
        win = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                win    = '0;
                win[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb_poll_counter.sv
`timescale 1ns/1ps
// Module: arb_poll_counter
// Device-number counter for polling. It advances one step per arbitration
// cycle until the polled device is requesting, then holds. On the end of an
// occupancy it restarts at zero, or keeps its value when RESUME is set.
// Assumes: step_en is only high when no grant is held and the bus is free.
module arb_poll_counter #(
    parameter int N      = 8,
    parameter bit RESUME = 1'b0,
    localparam int IDW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_en,
    input  logic           release_now,
    input  logic [N-1:0]   req,
    output logic [IDW-1:0] cnt,
    output logic           hit
);
    localparam logic [IDW-1:0] LAST = IDW'(N - 1);

    assign hit = req[cnt];

    // counter: restart or keep on release, advance while the polled device is silent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (release_now) begin
            if (!RESUME) cnt <= '0;
        end else if (step_en && !hit) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !hit && cnt == LAST && !release_now) |=> (cnt == '0));
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !hit && cnt != LAST && !release_now) |=> (cnt == $past(cnt) + 1'b1));
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !release_now) |=> $stable(cnt));
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (release_now && !RESUME) |=> (cnt == '0));
endmodule

// File: rtl/bus_arbiter_multi.sv
`timescale 1ns/1ps
// Module: bus_arbiter_multi
// Centralized arbiter with three selectable schemes: position chain, counter
// polling, and dedicated request/grant pairs. The grant is registered and held
// for the owner's occupancy, which ends when the owner drops bus_busy.
// Assumes: the owner raises bus_busy in the cycle after its grant appears and
// keeps it high until it is done; bus_busy high with no owner blocks arbitration.
module bus_arbiter_multi #(
    parameter int N_MASTERS   = 8,
    parameter bit POLL_RESUME = 1'b0,
    localparam int IDW        = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           scheme_sel,
    input  logic [N_MASTERS-1:0] bus_req,
    input  logic                 bus_busy,
    output logic [N_MASTERS-1:0] bus_grant,
    output logic [IDW-1:0]       poll_addr
);
    import arb_pkg::*;

    sched_e               scheme;
    logic [N_MASTERS-1:0] grant_q, grant_d;
    logic [N_MASTERS-1:0] chain_win, indep_win, poll_win;
    logic                 bus_free, arbitrate, release_now, poll_step, poll_hit;
    logic [IDW-1:0]       cnt;

    assign scheme      = sched_e'(scheme_sel);
    assign bus_free    = (grant_q == '0) && !bus_busy;
    assign arbitrate   = bus_free && (bus_req != '0);
    assign release_now = (grant_q != '0) && !bus_busy;
    assign poll_step   = arbitrate && (scheme == SCH_POLL);

    arb_daisy_chain #(.N(N_MASTERS)) u_chain (
        .req (bus_req),
        .win (chain_win)
    );

    arb_fixed_prio #(.N(N_MASTERS)) u_indep (
        .req (bus_req),
        .win (indep_win)
    );

    arb_poll_counter #(.N(N_MASTERS), .RESUME(POLL_RESUME)) u_poll (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (poll_step),
        .release_now (release_now),
        .req         (bus_req),
        .cnt         (cnt),
        .hit         (poll_hit)
    );

    // polled winner: the device whose number is on the address bus
    assign poll_win = poll_hit ? (N_MASTERS'(1) << cnt) : '0;

    // next grant: hold, release, or pick per scheme when the bus is free
    always_comb begin
        grant_d = grant_q;
        if (release_now) begin
            grant_d = '0;
        end else if (arbitrate) begin
            unique case (scheme)
                SCH_CHAIN: grant_d = chain_win;
                SCH_INDEP: grant_d = indep_win;
                SCH_POLL:  grant_d = poll_win;
                default:   grant_d = '0;
            endcase
        end
    end

    // grant register
    always_ff @(posedge clk) begin
        if (!rst_n) grant_q <= '0;
        else        grant_q <= grant_d;
    end

    assign bus_grant = grant_q;
    assign poll_addr = cnt;

    p_one_owner_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_grant));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant != '0 && bus_busy) |=> $stable(bus_grant));
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant != '0 && !bus_busy) |=> (bus_grant == '0));
    p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant == '0 && (bus_busy || bus_req == '0)) |=> (bus_grant == '0));
    p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant == '0 && scheme_sel == 2'd3) |=> (bus_grant == '0));
    p_poll_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant == '0 && !bus_busy && scheme_sel == 2'd1 && bus_req[poll_addr])
        |=> (bus_grant[poll_addr] && $stable(poll_addr)));
    p_chain_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant == '0 && !bus_busy && scheme_sel == 2'd0 && bus_req[0])
        |=> bus_grant[0]);
endmodule

// File: tb/bus_arbiter_multi_test.sv
`timescale 1ns/1ps
module bus_arbiter_multi_test;
    localparam int N   = 8;
    localparam int IDW = $clog2(N);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     scheme_sel = 2'd0;
    logic [N-1:0]   bus_req = '0;
    logic           bus_busy = 1'b0;
    logic [N-1:0]   g0, g1;
    logic [IDW-1:0] a0, a1;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [N-1:0] m_gnt [2];
    int           m_cnt [2];

    always #5 clk = ~clk;

    bus_arbiter_multi #(.N_MASTERS(N), .POLL_RESUME(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .scheme_sel(scheme_sel), .bus_req(bus_req),
        .bus_busy(bus_busy), .bus_grant(g0), .poll_addr(a0));

    bus_arbiter_multi #(.N_MASTERS(N), .POLL_RESUME(1'b1)) uut_rsm (
        .clk(clk), .rst_n(rst_n), .scheme_sel(scheme_sel), .bus_req(bus_req),
        .bus_busy(bus_busy), .bus_grant(g1), .poll_addr(a1));

    function automatic logic [N-1:0] lowest(input logic [N-1:0] r);
        for (int i = 0; i < N; i++)
            if (r[i]) return N'(1) << i;
        return '0;
    endfunction

    // expected next state of one copy, from the requirements
    task automatic model_step(input int k);
        if (!rst_n) begin
            m_gnt[k] = '0; m_cnt[k] = 0;                     // R2
        end else if (m_gnt[k] != '0) begin
            if (!bus_busy) begin                             // R8 / R6
                m_gnt[k] = '0;
                if (k == 0) m_cnt[k] = 0;
            end                                              // else R7 hold
        end else if (bus_busy || bus_req == '0) begin
            // R9 blocked
        end else begin
            case (scheme_sel)
                2'd0, 2'd2: m_gnt[k] = lowest(bus_req);       // R3, R4
                2'd1: begin                                   // R5
                    if (bus_req[m_cnt[k]]) m_gnt[k] = N'(1) << m_cnt[k];
                    else m_cnt[k] = (m_cnt[k] == N - 1) ? 0 : m_cnt[k] + 1;
                end
                default: ;                                    // R10
            endcase
        end
    endtask

    task automatic check(input string tag, input logic [N-1:0] got_g,
                         input logic [IDW-1:0] got_a, input int k);
        vectors++;
        if (got_g !== m_gnt[k] || int'(got_a) != m_cnt[k]) begin
            errors++;
            $display("FAIL %s copy%0d: grant=%b addr=%0d expected grant=%b addr=%0d",
                     tag, k, got_g, got_a, m_gnt[k], m_cnt[k]);
        end
        vectors++;
        if (!$onehot0(got_g)) begin
            errors++;
            $display("FAIL R1 copy%0d: grant=%b expected at most one bit", k, got_g);
        end
    endtask

    // one clock: model takes current inputs, then compare after the edge
    task automatic cyc(input string tag);
        model_step(0);
        model_step(1);
        @(posedge clk);
        @(negedge clk);
        check(tag, g0, a0, 0);
        check(tag, g1, a1, 1);
    endtask

    task automatic set_in(input logic [1:0] s, input logic [N-1:0] r, input logic b);
        scheme_sel = s; bus_req = r; bus_busy = b;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_gnt[0] = 'x; m_gnt[1] = 'x; m_cnt[0] = 0; m_cnt[1] = 0;
        @(negedge clk);
        rst_n = 1'b0;
        set_in(2'd0, 8'hFF, 1'b0);
        repeat (3) cyc("R2");
        rst_n = 1'b1;

        // R3: chain picks lowest of several
        set_in(2'd0, 8'b0110_1000, 1'b0); cyc("R3");
        set_in(2'd2, 8'b0000_0001, 1'b1); cyc("R7");    // R7: mode/request change ignored
        set_in(2'd2, 8'b0000_0000, 1'b0); cyc("R8");    // R8: release, no same-edge grant
        // R4: dedicated pairs pick lowest
        set_in(2'd2, 8'b1010_0100, 1'b0); cyc("R4");
        set_in(2'd2, 8'b1010_0100, 1'b0); cyc("R8");
        // R9: busy with no owner blocks
        set_in(2'd1, 8'b1000_0000, 1'b1); cyc("R9");
        set_in(2'd1, 8'b0000_0000, 1'b0); cyc("R9");
        // R5: lone top requester, counter walks to 7
        set_in(2'd1, 8'b1000_0000, 1'b0);
        for (int i = 0; i < 9; i++) begin
            cyc("R5");
            if (m_gnt[0] != '0) bus_busy = 1'b1;
        end
        set_in(2'd1, 8'b0000_0100, 1'b0); cyc("R6");    // R6: restart vs resume
        for (int i = 0; i < 9; i++) begin
            cyc("R6");
            if (m_gnt[0] != '0 && m_gnt[1] != '0) bus_busy = 1'b1;
        end
        bus_busy = 1'b0; cyc("R8");
        // R5: wrap from N-1 to 0 on the resuming copy
        set_in(2'd1, 8'b0000_0001, 1'b0);
        for (int i = 0; i < 10; i++) cyc("R5");
        set_in(2'd1, 8'b0000_0000, 1'b0); cyc("R8");
        // R10: reserved mode never grants
        set_in(2'd3, 8'hFF, 1'b0);
        for (int i = 0; i < 4; i++) cyc("R10");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [N-1:0] r;
            r = N'($urandom) & N'($urandom);
            scheme_sel = 2'($urandom_range(0, 3));
            bus_req = r;
            if (m_gnt[0] != '0 || m_gnt[1] != '0)
                bus_busy = ($urandom_range(0, 3) != 0);
            else
                bus_busy = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 199) == 0) rst_n = 1'b0;
            else rst_n = 1'b1;
            cyc("R5/R7");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule